// File: doc/BRIEF.md
# Three-Channel Quadrature Decoder

This block turns the signals of an incremental rotary encoder into three numbers that a host can read. Three cooperating counter channels share the work. The position channel decodes the two phase lines in four-edge mode and keeps a signed position. The revolution channel counts index pulses, stepping up or down by the most recent direction of motion, and each index pulse also returns the position to zero. The time-base channel sets a fixed measurement window. At the end of each window it latches how many valid phase edges arrived during that window, and that count is the speed value.

All three encoder lines pass through two-flop synchronisers before any edge is decoded. When both phase lines change in the same sampled cycle, the change is treated as a fault. The position stays as it was and a sticky error bit is set. Results are read through a small register port. The read address selects a word, and the data appears combinationally on a 32-bit output.

Top module: `quad_tri_decoder`

## Requirements
- R1: After synchronous reset, all four readable words (position, revolutions, speed, status) read as zero.
- R2: Phase states are {A,B}. A transition 00→01→11→10→00, one step at a time, increments the position by one per step.
- R3: A transition through those states in the opposite order decrements the position by one per step and sets the reverse bit (status bit 1). A forward step clears the reverse bit.
- R4: If both phase lines change in the same sampled cycle, the position does not change and the error bit (status bit 0) is set. The error bit stays set until reset.
- R5: Position and revolution words are sign-extended two's complement, so position −2 reads 0xFFFFFFFE.
- R6: A rising edge on the synchronised index line clears the position to zero. The clear takes priority over a phase step in the same cycle.
- R7: On each index rising edge, the revolution count increments if the reverse bit is clear and decrements if it is set.
- R8: An index line held high changes the revolution count only once.
- R9: While speed measurement is enabled, every WIN_CYCLES clocks the number of valid steps in either direction seen in that window is latched into the speed word, and counting restarts. Faulty transitions are not counted.
- R10: While speed measurement is disabled, the window counter and step accumulator stay at zero and the speed word keeps its last value.
- R11: A phase change that is stable before a rising clock edge shows up in the position word after the third rising edge and not before (two synchroniser stages plus one decode register).
- R12: Read address 0 selects position, 1 selects revolutions, 2 selects speed (zero-extended) and 3 selects status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index pulse, asynchronous |
| speed_en | input | 1 | Enables the speed time base |
| rd_addr | input | 2 | Register word select |
| rd_data | output | 32 | Selected register word |

## Verification
The checks assume the encoder lines move at most one Gray step per synchronised sample, except where a fault is meant to be injected. They also assume that a rise of the index line is not combined with a phase step in the same cycle. Under those conditions the position changes by at most one per cycle, and the revolution count and speed word change only on an index rise or at a window end. The stimulus holds every phase state and index level for several clocks, so each change passes the synchronisers alone. Double-line changes are driven only on purpose, as fault cases. Random forward, reverse and index moves are mixed with directed cases for latency, sign extension, a held index and the speed windows.

// File: rtl/qtd_pkg.sv
package qtd_pkg;

    localparam int RD_W = 32;

    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_FWD  = 2'd1,
        MOVE_REV  = 2'd2,
        MOVE_BAD  = 2'd3
    } move_e;

    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_REV  = 2'd1,
        SEL_SPD  = 2'd2,
        SEL_STAT = 2'd3
    } sel_e;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    typedef struct packed {
        logic reverse;
        logic fault;
    } status_t;

    // Position of a phase state along the forward Gray cycle.
    function automatic logic [1:0] phase_slot(input phase_t p);
        logic [1:0] s;
        case ({p.a, p.b})
            2'b00:   s = 2'd0;
            2'b01:   s = 2'd1;
            2'b11:   s = 2'd2;
            default: s = 2'd3;
        endcase
        return s;
    endfunction

    function automatic move_e classify(input phase_t prev, input phase_t cur);
        logic [1:0] d;
        move_e      m;
        d = phase_slot(cur) - phase_slot(prev);
        case (d)
            2'd1:    m = MOVE_FWD;
            2'd3:    m = MOVE_REV;
            2'd2:    m = MOVE_BAD;
            default: m = MOVE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/qtd_sync.sv
module qtd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/qtd_pos_chan.sv
module qtd_pos_chan
    import qtd_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_t           ph,
    input  logic             idx_rise,
    output logic [POS_W-1:0] pos_q,
    output move_e            mv,
    output status_t          stat
);
    phase_t last;

    always_ff @(posedge clk) begin
        if (rst) last <= '0;
        else     last <= ph;
    end

    assign mv = classify(last, ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (idx_rise) begin
            pos_q <= '0;
        end else begin
            case (mv)
                MOVE_FWD: pos_q <= pos_q + POS_W'(1);
                MOVE_REV: pos_q <= pos_q - POS_W'(1);
                default:  pos_q <= pos_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            if (mv == MOVE_FWD) stat.reverse <= 1'b0;
            if (mv == MOVE_REV) stat.reverse <= 1'b1;
            if (mv == MOVE_BAD) stat.fault   <= 1'b1;
        end
    end
endmodule

// File: rtl/qtd_rev_chan.sv
module qtd_rev_chan #(
    parameter int REV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx,
    input  logic             reverse,
    output logic             idx_rise,
    output logic [REV_W-1:0] rev_q
);
    logic idx_last;

    always_ff @(posedge clk) begin
        if (rst) idx_last <= 1'b0;
        else     idx_last <= idx;
    end

    assign idx_rise = idx & ~idx_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rev_q <= '0;
        end else if (idx_rise) begin
            if (reverse) rev_q <= rev_q - REV_W'(1);
            else         rev_q <= rev_q + REV_W'(1);
        end
    end
endmodule

// File: rtl/qtd_time_chan.sv
module qtd_time_chan
    import qtd_pkg::*;
#(
    parameter int SPD_W      = 16,
    parameter int WIN_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  move_e            mv,
    output logic [SPD_W-1:0] speed_q,
    output logic             win_end
);
    localparam int CNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);
    localparam logic [SPD_W-1:0] ACC_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [SPD_W-1:0] acc;
    logic [SPD_W-1:0] acc_next;
    logic             hit;

    assign hit      = (mv == MOVE_FWD) || (mv == MOVE_REV);
    assign acc_next = (hit && acc != ACC_MAX) ? acc + SPD_W'(1) : acc;
    assign win_end  = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            acc <= '0;
        end else if (win_end) begin
            cnt <= '0;
            acc <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
            acc <= acc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          speed_q <= '0;
        else if (win_end) speed_q <= acc_next;
    end
endmodule

// File: rtl/quad_tri_decoder.sv
module quad_tri_decoder
    import qtd_pkg::*;
#(
    parameter int POS_W      = 16,
    parameter int REV_W      = 16,
    parameter int SPD_W      = 16,
    parameter int WIN_CYCLES = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enc_a,
    input  logic            enc_b,
    input  logic            enc_idx,
    input  logic            speed_en,
    input  logic [1:0]      rd_addr,
    output logic [RD_W-1:0] rd_data
);
    logic [2:0]       raw_in;
    logic [2:0]       syn;
    phase_t           ph_s;
    logic             idx_s;
    logic             idx_rise;
    logic [POS_W-1:0] pos_q;
    logic [REV_W-1:0] rev_q;
    logic [SPD_W-1:0] speed_q;
    logic             win_end;
    move_e            mv;
    status_t          stat;

    assign raw_in = {enc_a, enc_b, enc_idx};

    qtd_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (syn)
    );

    assign ph_s  = '{a: syn[2], b: syn[1]};
    assign idx_s = syn[0];

    qtd_pos_chan #(.POS_W(POS_W)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph_s),
        .idx_rise (idx_rise),
        .pos_q    (pos_q),
        .mv       (mv),
        .stat     (stat)
    );

    qtd_rev_chan #(.REV_W(REV_W)) u_rev (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx_s),
        .reverse  (stat.reverse),
        .idx_rise (idx_rise),
        .rev_q    (rev_q)
    );

    qtd_time_chan #(.SPD_W(SPD_W), .WIN_CYCLES(WIN_CYCLES)) u_time (
        .clk     (clk),
        .rst     (rst),
        .en      (speed_en),
        .mv      (mv),
        .speed_q (speed_q),
        .win_end (win_end)
    );

    always_comb begin
        case (sel_e'(rd_addr))
            SEL_POS:  rd_data = {{(RD_W-POS_W){pos_q[POS_W-1]}}, pos_q};
            SEL_REV:  rd_data = {{(RD_W-REV_W){rev_q[REV_W-1]}}, rev_q};
            SEL_SPD:  rd_data = {{(RD_W-SPD_W){1'b0}}, speed_q};
            default:  rd_data = {{(RD_W-2){1'b0}}, stat.reverse, stat.fault};
        endcase
    end
endmodule

// File: rtl/qtd_checker.sv
module qtd_checker #(
    parameter int POS_W = 16,
    parameter int REV_W = 16,
    parameter int SPD_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       syn,
    input logic [POS_W-1:0] pos_q,
    input logic [REV_W-1:0] rev_q,
    input logic [SPD_W-1:0] speed_q,
    input logic             win_end,
    input logic [1:0]       stat
);
    logic [2:0] syn_prev;
    logic       rise;
    logic       both_flip;

    always_ff @(posedge clk) begin
        if (rst) syn_prev <= '0;
        else     syn_prev <= syn;
    end

    assign rise      = syn[0] & ~syn_prev[0];
    assign both_flip = (syn[2] != syn_prev[2]) && (syn[1] != syn_prev[1]);

    AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (both_flip && !rise) |=> ($stable(pos_q) && stat[0]));            // R4
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        stat[0] |=> stat[0]);                                             // R4
    AST_POS_UNIT: assert property (@(posedge clk) disable iff (rst)
        !rise |=> ((pos_q == $past(pos_q)) ||
                   ((pos_q - $past(pos_q)) == POS_W'(1)) ||
                   (($past(pos_q) - pos_q) == POS_W'(1))));               // R2
    AST_IDX_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rise |=> (pos_q == '0));                                          // R6
    AST_REV_UNIT: assert property (@(posedge clk) disable iff (rst)
        rise |=> (((rev_q - $past(rev_q)) == REV_W'(1)) ||
                  (($past(rev_q) - rev_q) == REV_W'(1))));                // R7
    AST_REV_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(rev_q));                                        // R8
    AST_SPEED_HELD: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(speed_q));                                   // R9
endmodule

bind quad_tri_decoder qtd_checker #(
    .POS_W (POS_W),
    .REV_W (REV_W),
    .SPD_W (SPD_W)
) u_qtd_chk (
    .clk     (clk),
    .rst     (rst),
    .syn     (syn),
    .pos_q   (pos_q),
    .rev_q   (rev_q),
    .speed_q (speed_q),
    .win_end (win_end),
    .stat    ({stat.reverse, stat.fault})
);

// File: tb/tb_quad_tri_decoder.sv
module tb_quad_tri_decoder;
    localparam int POS_W = 16;
    localparam int REV_W = 16;
    localparam int SPD_W = 16;
    localparam int WIN   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic        enc_idx = 1'b0;
    logic        speed_en = 1'b0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    int ph = 0;
    int m_pos = 0;
    int m_rev = 0;
    bit m_reverse = 0;
    bit m_fault = 0;
    int m_steps = 0;

    always #2 clk = ~clk;

    quad_tri_decoder #(
        .POS_W(POS_W), .REV_W(REV_W), .SPD_W(SPD_W), .WIN_CYCLES(WIN)
    ) dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .speed_en(speed_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [1:0] gray_of(input int slot);
        case (slot % 4)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [31:0] sext_pos(input int v);
        logic [POS_W-1:0] t;
        t = v[POS_W-1:0];
        return {{(32-POS_W){t[POS_W-1]}}, t};
    endfunction

    function automatic logic [31:0] sext_rev(input int v);
        logic [REV_W-1:0] t;
        t = v[REV_W-1:0];
        return {{(32-REV_W){t[REV_W-1]}}, t};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] addr, input logic [31:0] exp);
        rd_addr = addr;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, addr, rd_data, exp);
        end
    endtask

    // kind: 0 forward, 1 reverse, 2 both lines flip
    task automatic move(input int kind);
        case (kind)
            0: begin ph = (ph + 1) % 4; m_pos++; m_reverse = 0; m_steps++; end
            1: begin ph = (ph + 3) % 4; m_pos--; m_reverse = 1; m_steps++; end
            default: begin ph = (ph + 2) % 4; m_fault = 1; end
        endcase
        {enc_a, enc_b} = gray_of(ph);
        tick(4);
    endtask

    task automatic index_pulse(input int high_cycles);
        enc_idx = 1'b1;
        tick(high_cycles);
        enc_idx = 1'b0;
        tick(4);
        m_pos = 0;
        m_rev = m_reverse ? m_rev - 1 : m_rev + 1;
    endtask

    function automatic logic [31:0] stat_word();
        return {30'd0, m_reverse, m_fault};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset values
        check("R1 pos", 2'd0, 32'd0);
        check("R1 rev", 2'd1, 32'd0);
        check("R1 speed", 2'd2, 32'd0);
        check("R1 status", 2'd3, 32'd0);

        // R11 latency: change driven after a falling edge
        ph = 1; {enc_a, enc_b} = gray_of(ph); m_pos = 1;
        tick(2);
        check("R11 before third edge", 2'd0, 32'd0);
        tick(1);
        check("R11 after third edge", 2'd0, 32'd1);
        tick(1);

        // R2 forward steps
        repeat (4) move(0);
        check("R2 forward count", 2'd0, sext_pos(m_pos));
        check("R3 forward clears reverse", 2'd3, stat_word());

        // R3 / R5 reverse past zero
        repeat (7) move(1);
        check("R3 reverse count", 2'd0, sext_pos(m_pos));
        check("R5 negative sign extension", 2'd0, 32'hFFFF_FFFE);
        check("R3 reverse bit", 2'd3, 32'd2);

        // R6 / R7 index while moving in reverse
        index_pulse(4);
        check("R6 index clears position", 2'd0, 32'd0);
        check("R7 reverse index decrements", 2'd1, 32'hFFFF_FFFF);

        // R8 long index, forward direction
        move(0);
        index_pulse(25);
        check("R8 held index counts once", 2'd1, sext_rev(m_rev));
        check("R8 position cleared", 2'd0, 32'd0);

        // random mix
        for (int i = 0; i < 150; i++) begin
            int r;
            r = $urandom % 12;
            if (r < 5)       move(0);
            else if (r < 10) move(1);
            else             index_pulse(2 + ($urandom % 6));
            check("R2 R3 R6 random position", 2'd0, sext_pos(m_pos));
            if (r >= 10) check("R7 random revolutions", 2'd1, sext_rev(m_rev));
        end
        check("R12 status word", 2'd3, stat_word());

        // R4 faulty transition
        begin
            int held;
            held = m_pos;
            move(2);
            check("R4 position unchanged", 2'd0, sext_pos(held));
            check("R4 fault bit", 2'd3, stat_word());
            move(0);
            check("R4 fault sticky", 2'd3, stat_word());
            check("R2 step after fault", 2'd0, sext_pos(m_pos));
        end

        // R9 speed window
        speed_en = 1'b1;
        tick(2);
        repeat (5) move(0);
        repeat (3) move(1);
        move(2);
        tick(WIN + 2 - 38);
        check("R9 speed latched", 2'd2, 32'd8);

        // R10 disabled time base keeps value
        speed_en = 1'b0;
        repeat (3) move(0);
        tick(WIN + 8);
        check("R10 speed retained", 2'd2, 32'd8);

        // R9 idle window gives zero
        speed_en = 1'b1;
        tick(WIN + 2);
        check("R9 idle window", 2'd2, 32'd0);
        check("R12 position word", 2'd0, sext_pos(m_pos));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule